// File: doc/BRIEF.md
# Maskable Edge/Level Status Interrupt Unit

This block gathers a set of internal condition inputs into one status register that a host reads over a simple register bus. It also drives a single interrupt output. Each condition input first passes through a synchroniser. It is then judged by its own sensitivity setting, which is one of level, rising edge or falling edge. The result goes into that source's status bit.

In level mode a status bit simply tracks the synchronised input. In the two edge modes the bit captures an event and holds it until the host reads the status register. A per-source mask bit keeps a source from raising the interrupt. A masked source still records its status, so the host can poll it.

The bus has four word addresses. Address 0 is status (read only, and reading it clears edge events). Address 1 is the mask. Address 2 is the rising-select vector and address 3 is the falling-select vector. Bit i of each word belongs to source i.

Top module: `cond_irq_unit`

## Requirements
- R1: After reset the status reads 0, the mask (address 1) reads all ones, both select vectors (addresses 2 and 3) read 0, and irqOut is low.
- R2: A write with regWrEn high to address 1, 2 or 3 is visible on regRdData from the following cycle, with source i in bit i.
- R3: A source whose select pair {fall, rise} is 00 is level sensitive. Its status bit equals the condition input SYNC_STAGES+1 clock edges after the input changes, and it follows the input both up and down.
- R4: Select pair 01 is rising-edge mode. A 0-to-1 transition of the synchronised input sets the status bit, and the bit stays set after the input returns low.
- R5: Select pair 10 is falling-edge mode. A 1-to-0 transition sets the status bit, and a 0-to-1 transition leaves it unchanged.
- R6: A cycle with regRdEn high and regAddr 0 shows the status value before clearing on regRdData. At that clock edge it clears every edge-mode status bit.
- R7: An edge that is latched at the same clock edge as a clearing status read is kept in the status register.
- R8: irqOut is high exactly when some status bit is set whose mask bit (1 = masked) is 0. Masked sources still update their status bits.
- R9: Writes to address 0 leave the status register unchanged.
- R10: Select pair 11 behaves as level sensitive, with no sticky hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| condIn | input | NUM_SRC | Asynchronous condition inputs, one per source |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; at address 0 it clears edge events |
| regAddr | input | 2 | Register word address |
| regWrData | input | NUM_SRC | Write data |
| regRdData | output | NUM_SRC | Read data for regAddr, combinational from register state |
| irqOut | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
A change on condIn reaches its status bit after SYNC_STAGES+1 rising edges: two for synchronising and one for the status register. irqOut and regRdData are combinational from the registers, so they follow in the same cycle. A register write appears one edge after its strobe, and a clearing read takes effect at the edge during which regRdEn is high. The bench drives every input on the falling edge and counts exactly that many falling edges before it samples. The collision case places the read strobe on the third edge after the input change, so the read and the edge event meet in the same cycle.

// File: rtl/cond_irq_pkg.sv
package cond_irq_pkg;

  // Per-source sensitivity, encoded as {fallSel, riseSel}
  typedef enum logic [1:0] {
    SENS_LEVEL     = 2'b00,
    SENS_RISE      = 2'b01,
    SENS_FALL      = 2'b10,
    SENS_LEVEL_ALT = 2'b11
  } sens_e;

  // Register word addresses
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_RISE   = 2'd2;
  localparam logic [1:0] ADDR_FALL   = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic statusRd;
  } ctlStrobe_t;

endpackage

// File: rtl/cond_irq_ctrl.sv
module cond_irq_ctrl
  import cond_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] riseSel,
  output logic [NUM_SRC-1:0] fallSel,
  output ctlStrobe_t         strb,
  output logic [NUM_SRC-1:0] regRdData
);

  logic maskWr, riseWr, fallWr;

  assign maskWr = regWrEn && (regAddr == ADDR_MASK);
  assign riseWr = regWrEn && (regAddr == ADDR_RISE);
  assign fallWr = regWrEn && (regAddr == ADDR_FALL);

  assign strb.statusRd = regRdEn && (regAddr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ   <= '1;
      riseSel <= '0;
      fallSel <= '0;
    end else begin
      if (maskWr) maskQ   <= regWrData;
      if (riseWr) riseSel <= regWrData;
      if (fallWr) fallSel <= regWrData;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS: regRdData = statusQ;
      ADDR_MASK:   regRdData = maskQ;
      ADDR_RISE:   regRdData = riseSel;
      default:     regRdData = fallSel;
    endcase
  end

endmodule

// File: rtl/cond_irq_datapath.sv
module cond_irq_datapath
  import cond_irq_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic [NUM_SRC-1:0] riseSel,
  input  logic [NUM_SRC-1:0] fallSel,
  input  logic [NUM_SRC-1:0] maskQ,
  input  ctlStrobe_t         strb,
  output logic [NUM_SRC-1:0] statusQ,
  output logic               irqOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] statusNxt;

  // Synchroniser chain followed by one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= condIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= syncQ[LAST];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic  cur, prv, risePulse, fallPulse, held;
    sens_e sens;

    assign cur       = syncQ[LAST][i];
    assign prv       = prevQ[i];
    assign risePulse = cur & ~prv;
    assign fallPulse = ~cur & prv;
    assign held      = statusQ[i] & ~strb.statusRd;
    assign sens      = sens_e'({fallSel[i], riseSel[i]});

    assign statusNxt[i] = (sens == SENS_RISE) ? (held | risePulse) :
                          (sens == SENS_FALL) ? (held | fallPulse) :
                          cur;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= statusNxt;
  end

  assign irqOut = |(statusQ & ~maskQ);

endmodule

// File: rtl/cond_irq_unit.sv
module cond_irq_unit
  import cond_irq_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] statusQ, maskQ, riseSel, fallSel;
  ctlStrobe_t         strb;

  cond_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .statusQ   (statusQ),
    .maskQ     (maskQ),
    .riseSel   (riseSel),
    .fallSel   (fallSel),
    .strb      (strb),
    .regRdData (regRdData)
  );

  cond_irq_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .condIn  (condIn),
    .riseSel (riseSel),
    .fallSel (fallSel),
    .maskQ   (maskQ),
    .strb    (strb),
    .statusQ (statusQ),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/cond_irq_unit_chk.sv
module cond_irq_unit_chk
  import cond_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] riseSel,
  input logic [NUM_SRC-1:0] fallSel,
  input ctlStrobe_t         strb,
  input logic               irqOut
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (statusQ == '0 && maskQ == '1 && riseSel == '0 && fallSel == '0 && !irqOut));

  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (&maskQ) |-> !irqOut);

  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (|statusQ));

  assert_rise_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (statusQ[0] && !strb.statusRd && riseSel[0] && !fallSel[0])
    |=> (statusQ[0] || !riseSel[0] || fallSel[0]));

  assert_fall_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (statusQ[0] && !strb.statusRd && fallSel[0] && !riseSel[0])
    |=> (statusQ[0] || riseSel[0] || !fallSel[0]));

endmodule

bind cond_irq_unit cond_irq_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .riseSel (riseSel),
  .fallSel (fallSel),
  .strb    (strb),
  .irqOut  (irqOut)
);

// File: tb/cond_irq_unit_tb.sv
module cond_irq_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int LAT = 3;  // SYNC_STAGES + 1 edges

  typedef struct packed {
    logic [3:0] mask;
    logic [3:0] cond;
    logic       irq;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{mask: 4'b0000, cond: 4'b0001, irq: 1'b1},
    '{mask: 4'b0001, cond: 4'b0001, irq: 1'b0},
    '{mask: 4'b0001, cond: 4'b0011, irq: 1'b1},
    '{mask: 4'b1111, cond: 4'b1111, irq: 1'b0},
    '{mask: 4'b0111, cond: 4'b1010, irq: 1'b1},
    '{mask: 4'b0000, cond: 4'b0000, irq: 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] condIn = '0;
  logic         regWrEn = 1'b0;
  logic         regRdEn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic         irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cond_irq_unit #(.NUM_SRC(N), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .condIn    (condIn),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [N-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [N-1:0] v);
    regRdEn = 1'b0; regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic readClear(output logic [N-1:0] v);
    regAddr = 2'd0; regRdEn = 1'b1;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    waitN(3);
    rst = 1'b0;

    // R1 reset state
    peek(2'd0, v); chk("R1 status", v, 0);
    peek(2'd1, v); chk("R1 mask", v, 4'hF);
    peek(2'd2, v); chk("R1 rise", v, 0);
    peek(2'd3, v); chk("R1 fall", v, 0);
    chk("R1 irq", irqOut, 0);

    // R3 / R8 level-mode table
    for (int k = 0; k < NVEC; k++) begin
      regWrite(2'd1, VEC[k].mask);
      condIn = VEC[k].cond;
      waitN(LAT);
      peek(2'd0, v);
      chk("R3 level status", v, VEC[k].cond);
      chk("R8 irq", irqOut, VEC[k].irq);
    end

    // R2 readback
    regWrite(2'd1, 4'b0101);
    peek(2'd1, v); chk("R2 mask", v, 4'b0101);
    regWrite(2'd2, 4'b0011);
    regWrite(2'd3, 4'b0110);
    peek(2'd2, v); chk("R2 rise", v, 4'b0011);
    peek(2'd3, v); chk("R2 fall", v, 4'b0110);

    // R10 pair 11 on bit1 acts as level
    condIn = 4'b0010; waitN(LAT);
    peek(2'd0, v); chk("R10 follow high", v, 4'b0010);
    condIn = 4'b0000; waitN(LAT);
    peek(2'd0, v); chk("R10 follow low", v, 4'b0000);

    // R4 rising sticky, R6 clearing read
    regWrite(2'd2, 4'b1111);
    regWrite(2'd3, 4'b0000);
    regWrite(2'd1, 4'b0000);
    condIn = 4'b0001; waitN(LAT);
    peek(2'd0, v); chk("R4 rise set", v, 4'b0001);
    chk("R8 irq on edge", irqOut, 1);
    condIn = 4'b0000; waitN(LAT);
    peek(2'd0, v); chk("R4 sticky", v, 4'b0001);
    readClear(v); chk("R6 read data", v, 4'b0001);
    peek(2'd0, v); chk("R6 cleared", v, 4'b0000);
    chk("R6 irq low", irqOut, 0);

    // R7 edge on same edge as clearing read
    condIn = 4'b0001; waitN(LAT-1);
    readClear(v); chk("R7 pre-edge data", v, 4'b0000);
    peek(2'd0, v); chk("R7 edge kept", v, 4'b0001);
    condIn = 4'b0000; waitN(LAT);
    readClear(v);

    // R5 falling mode
    regWrite(2'd2, 4'b0000);
    regWrite(2'd3, 4'b1111);
    condIn = 4'b0010; waitN(LAT);
    peek(2'd0, v); chk("R5 rise ignored", v, 4'b0000);
    condIn = 4'b0000; waitN(LAT);
    peek(2'd0, v); chk("R5 fall set", v, 4'b0010);
    chk("R5 irq", irqOut, 1);

    // R8 masked sources still update
    regWrite(2'd1, 4'b0010);
    chk("R8 masked irq", irqOut, 0);
    readClear(v);
    regWrite(2'd1, 4'b1111);
    condIn = 4'b0100; waitN(LAT);
    condIn = 4'b0000; waitN(LAT);
    peek(2'd0, v); chk("R8 masked status", v, 4'b0100);
    chk("R8 masked quiet", irqOut, 0);
    regWrite(2'd1, 4'b0000);
    chk("R8 unmask irq", irqOut, 1);

    // R9 status not writable
    regWrite(2'd0, 4'b1111);
    peek(2'd0, v); chk("R9 write ignored", v, 4'b0100);
    regWrite(2'd0, 4'b0000);
    peek(2'd0, v); chk("R9 zero write ignored", v, 4'b0100);

    // R1 reset mid-run
    rst = 1'b1; waitN(2); rst = 1'b0;
    peek(2'd0, v); chk("R1 status after rst", v, 0);
    peek(2'd1, v); chk("R1 mask after rst", v, 4'hF);
    peek(2'd3, v); chk("R1 fall after rst", v, 0);
    chk("R1 irq after rst", irqOut, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule